// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer that counts system clock cycles and expects software to service it inside a time window. One byte-wide control register sits at a fixed bus address. It holds a run flag, a two-bit field that selects the time-out length and a three-bit field that selects the earliest cycle count at which servicing is allowed. While the run flag is set, the counter advances on every clock. Any write to the register restarts the count, even a write of the value already stored.

A violation raises a one-cycle pulse on `wdt_irq`. There are two kinds of violation. The first is a count that reaches the time-out length with no service. The second is a service write that arrives too early, while the count is still below the lower bound. In both cases the count restarts from zero. Software should set the fields first and set the run flag last. A write with the run flag cleared stores the fields and holds the counter at zero.

The `SHIFT` parameter lowers every window exponent by the same amount, so that short runs can exercise the full window behaviour. The register, the window decode, the counter and the violation pulse all belong to the block. The processor and the reset controller that react to the pulse are outside it.

Top module: `wdw_top`

## Requirements
- R1: A write with `bus_wr` high and `bus_addr` equal to `ADDR` stores `bus_wdata[5:0]`: bit 0 is the run flag, bits 2:1 are the time-out select and bits 5:3 are the lower-bound select. `bus_rdata` shows the stored bits with bits 7:6 as 0 when `bus_addr` equals `ADDR`, and shows 0 for any other address. A write to any other address has no effect.
- R2: After reset the stored register is 0, `bus_rdata` at `ADDR` reads 0 and `wdt_irq` is low.
- R3: While the stored run flag is 0, the counter stays at zero and `wdt_irq` never rises.
- R4: A write that sets the run flag starts a count. With no later write, `wdt_irq` pulses exactly T cycles after that write's clock edge. T is 2^(16+2·sel−SHIFT), so the time-out select codes 00, 01, 10 and 11 give 2^16, 2^18, 2^20 and 2^22 when SHIFT is 0.
- R5: After a time-out the count restarts from zero, and the next time-out pulse follows T cycles later.
- R6: While running, a write is a legal service when the count just before its edge is at least M. A legal service raises no pulse and restarts the count, so the next time-out comes T cycles after that write. This holds even when the written value equals the stored value.
- R7: While running, a write made when the count just before its edge is below M raises a one-cycle `wdt_irq` pulse on the next cycle and restarts the count. For lower-bound codes 1 to 7, M is 2^(7+sel−SHIFT), which gives 2^8 up to 2^14 when SHIFT is 0.
- R8: Lower-bound code 000 removes the lower bound, so a service write never raises a pulse.
- R9: `wdt_irq` rises only for the events in R4, R5 and R7, and each event gives a pulse exactly one cycle long.
- R10: A write that clears the run flag stops the counter and suppresses all later pulses until the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; the register when the address matches, else 0 |
| wdt_irq | output | 1 | One-cycle violation pulse |

## Verification
The hardest cases to reach from the ports are the boundaries of the window. A service write must land exactly one cycle before the lower bound and exactly on it, and the counter must run a full time-out with no help. The stimulus is a per-cycle driver that keeps its own model of the count since the last restart. It places writes a chosen number of cycles after a previous write, for example at counts M−1 and M for two different lower-bound codes. It then idles long enough for unassisted time-outs under every time-out code. Each expected pulse is queued with its cycle number before that cycle arrives, so a pulse that is missing, early or extra is caught.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  localparam int unsigned TO_EXP_BASE  = 16;
  localparam int unsigned MIN_EXP_BASE = 7;

  typedef struct packed {
    logic [2:0] min_sel;
    logic [1:0] tout_sel;
    logic       en;
  } wdw_ctrl_t;

endpackage

// File: rtl/wdw_regs.sv
module wdw_regs
  import wdw_pkg::*;
#(
  parameter logic [15:0] ADDR = 16'h3F02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output wdw_ctrl_t   ctrl,
  output logic        hit,
  output logic [7:0]  rdata
);

  logic sel;

  assign sel = (bus_addr == ADDR);
  assign hit = bus_wr && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (hit) begin
      ctrl <= wdw_ctrl_t'(bus_wdata[5:0]);
    end
  end

  assign rdata = sel ? {2'b00, 6'(ctrl)} : 8'h00;

endmodule

// File: rtl/wdw_limits.sv
module wdw_limits
  import wdw_pkg::*;
#(
  parameter int unsigned SHIFT = 0,
  parameter int unsigned CW    = 23
) (
  input  wdw_ctrl_t      ctrl,
  output logic [CW-1:0]  tout_lim,
  output logic [CW-1:0]  min_lim,
  output logic           min_on
);

  int unsigned tout_exp;
  int unsigned min_exp;

  always_comb begin
    tout_exp = TO_EXP_BASE + 2 * int'(ctrl.tout_sel) - SHIFT;
    tout_lim = CW'(1) << tout_exp;
  end

  always_comb begin
    min_on  = (ctrl.min_sel != 3'd0);
    min_exp = MIN_EXP_BASE + int'(ctrl.min_sel) - SHIFT;
    min_lim = min_on ? (CW'(1) << min_exp) : '0;
  end

endmodule

// File: rtl/wdw_counter.sv
module wdw_counter #(
  parameter int unsigned CW = 23
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           clr,
  input  logic [CW-1:0]  tout_lim,
  input  logic [CW-1:0]  min_lim,
  input  logic           min_on,
  output logic [CW-1:0]  cnt,
  output logic           irq
);

  logic early;
  logic expire;

  assign early  = min_on && (cnt < min_lim);
  assign expire = (cnt == tout_lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!run) begin
        cnt <= '0;
      end else if (clr) begin
        cnt <= '0;
        irq <= early;
      end else if (expire) begin
        cnt <= '0;
        irq <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/wdw_top.sv
module wdw_top
  import wdw_pkg::*;
#(
  parameter logic [15:0] ADDR  = 16'h3F02,
  parameter int unsigned SHIFT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        wdt_irq
);

  localparam int unsigned CW = TO_EXP_BASE + 2 * 3 - SHIFT + 1;

  wdw_ctrl_t      ctrl;
  logic           hit;
  logic           run;
  logic [CW-1:0]  tout_lim;
  logic [CW-1:0]  min_lim;
  logic           min_on;
  logic [CW-1:0]  cnt;

  assign run = ctrl.en;

  wdw_regs #(.ADDR(ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl      (ctrl),
    .hit       (hit),
    .rdata     (bus_rdata)
  );

  wdw_limits #(.SHIFT(SHIFT), .CW(CW)) u_limits (
    .ctrl     (ctrl),
    .tout_lim (tout_lim),
    .min_lim  (min_lim),
    .min_on   (min_on)
  );

  wdw_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clr      (hit),
    .tout_lim (tout_lim),
    .min_lim  (min_lim),
    .min_on   (min_on),
    .cnt      (cnt),
    .irq      (wdt_irq)
  );

endmodule

// File: rtl/wdw_chk.sv
module wdw_chk #(
  parameter int unsigned CW = 23
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic           hit,
  input logic           min_on,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  tout_lim,
  input logic [CW-1:0]  min_lim,
  input logic [7:0]     bus_rdata,
  input logic           wdt_irq
);

  AST_RDATA_RSVD: assert property (@(posedge clk) disable iff (!rst_n) bus_rdata[7:6] == 2'b00); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (cnt == '0 && !wdt_irq)); // R3
  AST_CNT_BELOW_TO: assert property (@(posedge clk) disable iff (!rst_n) run |-> cnt < tout_lim); // R4
  AST_SERVICE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (run && hit) |=> cnt == '0); // R6
  AST_EARLY_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (run && hit && min_on && cnt < min_lim) |=> wdt_irq); // R7
  AST_NOMIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (run && hit && !min_on) |=> !wdt_irq); // R8

endmodule

bind wdw_top wdw_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .hit       (hit),
  .min_on    (min_on),
  .cnt       (cnt),
  .tout_lim  (tout_lim),
  .min_lim   (min_lim),
  .bus_rdata (bus_rdata),
  .wdt_irq   (wdt_irq)
);

// File: tb/sim_wdw_top.sv
`timescale 1ns/1ps
module sim_wdw_top;

  localparam logic [15:0] ADDR  = 16'h3F02;
  localparam int unsigned SHIFT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        wdt_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct { int cyc; string tag; } exp_t;
  exp_t expq[$];

  bit    en_m = 1'b0;
  int    t_m = 0;
  int    m_m = 0;
  int    last_zero = 0;
  string lz_tag = "R4";

  wdw_top #(.ADDR(ADDR), .SHIFT(SHIFT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_irq(wdt_irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void push(int c, string tag);
    exp_t e;
    e.cyc = c;
    e.tag = tag;
    expq.push_back(e);
  endfunction

  // One bus cycle; the model predicts pulses for the coming edge.
  task automatic step(bit w, logic [15:0] a, logic [7:0] d);
    int e;
    bit hm;
    @(negedge clk);
    bus_wr = w;
    bus_addr = a;
    bus_wdata = d;
    e = cyc + 1;
    hm = w && (a == ADDR);
    if (en_m) begin
      if (hm) begin
        if ((e - 1 - last_zero) < m_m) push(e, "R7");
        last_zero = e;
        lz_tag = "R6";
      end else if (e - last_zero == t_m) begin
        push(e, lz_tag);
        last_zero = e;
        lz_tag = "R5";
      end
    end else if (hm) begin
      last_zero = e;
      lz_tag = "R4";
    end
    if (hm) begin
      en_m = d[0];
      t_m = 1 << (16 + 2 * int'(d[2:1]) - SHIFT);
      m_m = (d[5:3] == 3'd0) ? 0 : (1 << (7 + int'(d[5:3]) - SHIFT));
    end
  endtask

  task automatic wr(logic [7:0] d);
    step(1'b1, ADDR, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, ADDR, 8'h00);
  endtask

  task automatic rd_check(logic [15:0] a, logic [7:0] exp, string tag);
    step(1'b0, a, 8'h00);
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s readback: got %02h expected %02h", tag, bus_rdata, exp);
    end
  endtask

  // Monitor: pops expected pulses and compares them with the output.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (expq.size() > 0 && expq[0].cyc == cyc) begin
          it = expq.pop_front();
          checks++;
          if (wdt_irq !== 1'b1) begin
            errors++;
            $display("FAIL %s pulse at cycle %0d: got %b expected 1", it.tag, cyc, wdt_irq);
          end
        end else if (wdt_irq !== 1'b0) begin
          checks++;
          errors++;
          $display("FAIL R9 unexpected pulse at cycle %0d: got %b expected 0", cyc, wdt_irq);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (bus_rdata !== 8'h00 || wdt_irq !== 1'b0) begin
      errors++;
      $display("FAIL R2 in reset: got rdata %02h irq %b expected 00 0", bus_rdata, wdt_irq);
    end
    rst_n = 1'b1;
    rd_check(ADDR, 8'h00, "R2");

    // R1: reserved bits read 0; other addresses ignored and read 0
    wr(8'hFE);
    rd_check(ADDR, 8'h3E, "R1");
    step(1'b1, ADDR + 16'h1, 8'h01);
    rd_check(ADDR, 8'h3E, "R1");
    rd_check(ADDR + 16'h1, 8'h00, "R1");

    // R3: fields set, run flag clear, long idle, no pulse
    idle(1500);
    rd_check(ADDR, 8'h3E, "R3");

    // R4 and R5: enable with 1024-cycle time-out, lower bound 8
    wr(8'h11);
    idle(2100);

    // R6 and R7 boundary: counts 7 (early) then 8 (legal)
    wr(8'h11);
    idle(7);
    wr(8'h11);
    idle(8);
    wr(8'h11);
    // R6: same value rewritten, time-out postponed each time
    for (int k = 0; k < 3; k++) begin
      idle(900);
      wr(8'h11);
    end
    idle(1100);

    // R8: no lower bound, back-to-back service writes
    idle(50);
    wr(8'h01);
    for (int k = 0; k < 5; k++) wr(8'h01);
    idle(10);

    // R7 with lower bound code 111 (256), time-out code 01
    wr(8'h3B);
    idle(255);
    wr(8'h3B);
    idle(256);
    wr(8'h3B);
    idle(4200);

    // R4 with time-out codes 10 and 11
    wr(8'h04);
    wr(8'h05);
    idle(16500);
    wr(8'h06);
    wr(8'h07);
    idle(65700);

    // R10: run flag cleared, no further pulses
    wr(8'h10);
    rd_check(ADDR, 8'h10, "R10");
    idle(5000);

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R9 pending pulses: got %0d expected 0", expq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule